// File: doc/BRIEF.md
# Mixed strict-priority / deficit round-robin queue arbiter

This block chooses which of eight transmit queues sends its next frame. A programmable boundary splits the queues in two. Queues whose index is below the boundary form a weighted group, and they share bandwidth by deficit round robin. Queues at or above the boundary are served in strict priority, and a higher index beats a lower one. Any strict queue with a pending request beats the whole weighted group.

Each member of the weighted group has a programmed cost. Sending a frame charges the queue's balance by the frame length times (cost + 1), so a larger cost gives a queue less bandwidth. A rotating pointer keeps serving the same member while that member's balance is non-negative. When every requesting member is in debt, all of them receive the same fixed quantum. A host write port sets the boundary count and the per-queue costs. The arbiter issues one registered, one-hot grant per frame while downstream is ready.

Top module: `prio_dwrr_arb`

## Requirements
- R1: After reset, gnt_o is all zero, the count is 0 (every queue strict) and every cost is 0.
- R2: A grant appears on gnt_o at the clock edge that samples ready_i high with at least one request, and lasts one cycle. When ready_i is low or no request is present, gnt_o is zero after that edge.
- R3: gnt_o has at most one bit set, and only for a queue whose request was high in the cycle that produced it.
- R4: Queues with index greater than or equal to the count are strict, and the highest requesting strict index is granted.
- R5: While any strict queue requests, no queue below the count is granted.
- R6: Count 0 makes all queues strict and count 8 makes all queues weighted. A count write above 8 is stored as 8.
- R7: A host write with cfg_addr_i equal to 8 sets the count from cfg_wdata_i[3:0]. A write with cfg_addr_i in 0..7 sets that queue's 6-bit cost. Writes to addresses above 8 are ignored. A written value governs arbitration from the cycle after the write edge.
- R8: Granting weighted queue q subtracts len × (cost_q + 1) from its balance. The grant goes to the first requesting member with a non-negative balance, searching in rising index order (with wrap-around) from the pointer. If the grant leaves that member's balance negative, the pointer moves to the next index (7 wraps to 0). Otherwise the pointer stays on that member.
- R9: On a weighted turn where no requesting member has a non-negative balance, every requesting member gains QUANTUM, and the selection is made on the raised balances in that same cycle. If a balance is still negative after the raise, no grant is made that cycle.
- R10: A queue that is not requesting, or is not a weighted member, has its balance cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Per-queue frame-pending flags |
| len_i | input | 112 | Per-queue head frame length, 14 bits each, queue q at [14q+13:14q] |
| ready_i | input | 1 | Downstream can take a frame this cycle |
| cfg_we_i | input | 1 | Host write strobe |
| cfg_addr_i | input | 4 | 0..7 cost entry, 8 count register |
| cfg_wdata_i | input | 6 | Host write data |
| gnt_o | output | 8 | Registered one-hot grant, one cycle per frame |

## Verification
A grant is due one edge after the cycle whose requests, lengths and ready state produced it. The bench therefore drives each stimulus at a falling edge and reads gnt_o 1 ns after the next rising edge. A host write lands on the edge it is clocked by and first steers the grant produced one edge later. The bench holds requests low and ready low during every write cycle, so no grant depends on a write in flight. Balances and the pointer are not visible at the ports. An independent model of the charge, replenish and clearing rules predicts every grant, so a wrong balance shows up as a wrong queue or a missing grant several frames later.

// File: rtl/prio_dwrr_pkg.sv
package prio_dwrr_pkg;
  localparam int unsigned DEF_NUM_Q   = 8;
  localparam int unsigned DEF_LEN_W   = 14;
  localparam int unsigned DEF_COST_W  = 6;
  localparam int unsigned DEF_QUANTUM = 2048;

  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/prio_dwrr_cfg.sv
module prio_dwrr_cfg #(
  parameter int unsigned NUM_Q  = 8,
  parameter int unsigned COST_W = 6,
  parameter int unsigned AW     = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [COST_W-1:0]       wdata_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [NUM_Q*COST_W-1:0] cost_o,
  output logic [NUM_Q-1:0]        member_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (we_i && addr_i == AW'(NUM_Q)) begin
      if (wdata_i > COST_W'(NUM_Q)) cnt_q <= CNT_W'(NUM_Q);
      else                          cnt_q <= CNT_W'(wdata_i);
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_cost
    logic [COST_W-1:0] cost_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cost_q <= '0;
      else if (we_i && addr_i == AW'(q)) cost_q <= wdata_i;
    end
    assign cost_o[q*COST_W +: COST_W] = cost_q;
    assign member_o[q] = (CNT_W'(q) < cnt_q);
  end

  assign cnt_o = cnt_q;

  AST_CNT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(NUM_Q) && wdata_i <= COST_W'(NUM_Q)) |=> cnt_o == CNT_W'($past(wdata_i))); // R7
  AST_CNT_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(NUM_Q) && wdata_i > COST_W'(NUM_Q)) |=> cnt_o == CNT_W'(NUM_Q)); // R6
endmodule

// File: rtl/prio_dwrr_strict.sv
module prio_dwrr_strict #(
  parameter int unsigned NUM_Q = 8
) (
  input  logic [NUM_Q-1:0] req_i,
  input  logic [NUM_Q-1:0] member_i,
  output logic             any_o,
  output logic [NUM_Q-1:0] gnt_o
);
  logic [NUM_Q-1:0] cand;
  assign cand  = req_i & ~member_i;
  assign any_o = |cand;

  // later (higher) index overwrites earlier
  always_comb begin
    gnt_o = '0;
    for (int q = 0; q < NUM_Q; q++)
      if (cand[q]) gnt_o = NUM_Q'(1) << q;
  end
endmodule

// File: rtl/prio_dwrr_wrr.sv
module prio_dwrr_wrr
  import prio_dwrr_pkg::*;
#(
  parameter int unsigned NUM_Q   = 8,
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned COST_W  = 6,
  parameter int unsigned QUANTUM = 2048
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_Q-1:0]        req_i,
  input  logic [NUM_Q-1:0]        member_i,
  input  logic [NUM_Q*LEN_W-1:0]  len_i,
  input  logic [NUM_Q*COST_W-1:0] cost_i,
  input  logic                    take_i,
  output logic                    any_o,
  output logic [NUM_Q-1:0]        gnt_o
);
  localparam int unsigned CHG_W = LEN_W + COST_W;
  localparam int unsigned BAL_W = CHG_W + 2;
  localparam int unsigned IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic signed [BAL_W-1:0] bal_q   [NUM_Q];
  logic signed [BAL_W-1:0] bal_eff [NUM_Q];
  logic signed [BAL_W-1:0] bal_chg [NUM_Q];
  logic [CHG_W-1:0]        chg     [NUM_Q];
  logic [NUM_Q-1:0]        act, ok_now, elig;
  logic                    replen, found;
  logic [IDX_W-1:0]        ptr_q, pick;

  assign act   = req_i & member_i;
  assign any_o = |act;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_bal
    assign chg[q] = CHG_W'(len_i[q*LEN_W +: LEN_W]) *
                    (CHG_W'(cost_i[q*COST_W +: COST_W]) + CHG_W'(1));
    assign ok_now[q]  = act[q] && !bal_q[q][BAL_W-1];
    assign bal_eff[q] = (replen && act[q]) ? bal_q[q] + $signed(BAL_W'(QUANTUM)) : bal_q[q];
    assign bal_chg[q] = bal_eff[q] - $signed(BAL_W'(chg[q]));
    assign elig[q]    = act[q] && !bal_eff[q][BAL_W-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bal_q[q] <= '0;
      else if (!act[q]) bal_q[q] <= '0;
      else if (take_i)  bal_q[q] <= (found && pick == IDX_W'(q)) ? bal_chg[q] : bal_eff[q];
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act[q] |=> bal_q[q] == '0); // R10
    AST_BAL_BELOW_QUANTUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bal_q[q] < $signed(BAL_W'(QUANTUM))); // R9
  end

  assign replen = (act != '0) && (ok_now == '0);

  // first eligible member at or after the pointer
  always_comb begin : p_pick
    int unsigned k;
    found = 1'b0;
    pick  = '0;
    for (int unsigned i = 0; i < NUM_Q; i++) begin
      k = 32'(ptr_q) + i;
      if (k >= NUM_Q) k = k - NUM_Q;
      if (!found && elig[k]) begin
        found = 1'b1;
        pick  = IDX_W'(k);
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (found) gnt_o[pick] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (take_i && found) begin
      if (bal_chg[pick][BAL_W-1]) ptr_q <= IDX_W'(wrap_next(32'(pick), NUM_Q));
      else                        ptr_q <= pick;
    end
  end

  AST_PICK_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~act) == '0)); // R8
endmodule

// File: rtl/prio_dwrr_arb.sv
module prio_dwrr_arb
  import prio_dwrr_pkg::*;
#(
  parameter int unsigned NUM_Q   = DEF_NUM_Q,
  parameter int unsigned LEN_W   = DEF_LEN_W,
  parameter int unsigned COST_W  = DEF_COST_W,
  parameter int unsigned QUANTUM = DEF_QUANTUM,
  localparam int unsigned AW     = $clog2(NUM_Q) + 1,
  localparam int unsigned CNT_W  = $clog2(NUM_Q + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_Q-1:0]       req_i,
  input  logic [NUM_Q*LEN_W-1:0] len_i,
  input  logic                   ready_i,
  input  logic                   cfg_we_i,
  input  logic [AW-1:0]          cfg_addr_i,
  input  logic [COST_W-1:0]      cfg_wdata_i,
  output logic [NUM_Q-1:0]       gnt_o
);
  logic [CNT_W-1:0]        cnt;
  logic [NUM_Q*COST_W-1:0] cost;
  logic [NUM_Q-1:0]        member, strict_gnt, wrr_gnt, gnt_d;
  logic                    strict_any, wrr_any, wrr_take;

  prio_dwrr_cfg #(.NUM_Q(NUM_Q), .COST_W(COST_W), .AW(AW), .CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .cnt_o(cnt), .cost_o(cost), .member_o(member)
  );

  prio_dwrr_strict #(.NUM_Q(NUM_Q)) u_strict (
    .req_i, .member_i(member), .any_o(strict_any), .gnt_o(strict_gnt)
  );

  assign wrr_take = ready_i && !strict_any && wrr_any;

  prio_dwrr_wrr #(.NUM_Q(NUM_Q), .LEN_W(LEN_W), .COST_W(COST_W), .QUANTUM(QUANTUM)) u_wrr (
    .clk_i, .rst_ni, .req_i, .member_i(member), .len_i, .cost_i(cost),
    .take_i(wrr_take), .any_o(wrr_any), .gnt_o(wrr_gnt)
  );

  always_comb begin
    gnt_d = '0;
    if (ready_i) gnt_d = strict_any ? strict_gnt : wrr_gnt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_o <= '0;
    else         gnt_o <= gnt_d;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R3
  AST_GNT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (gnt_o & ~$past(req_i)) == '0); // R3
  AST_NO_GNT_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> gnt_o == '0); // R2
  AST_STRICT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && strict_any) |=> (gnt_o & $past(member)) == '0 && gnt_o != '0); // R5
  AST_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && req_i == '0) |=> gnt_o == '0); // R2
endmodule

// File: tb/prio_dwrr_arb_test.sv
module prio_dwrr_arb_test;
  localparam int NQ = 8;
  localparam int LW = 14;
  localparam int QUANT = 256;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NQ-1:0]  req_i = '0;
  logic [NQ*LW-1:0] len_i;
  logic           ready_i = 1'b0;
  logic           cfg_we_i = 1'b0;
  logic [3:0]     cfg_addr_i = '0;
  logic [5:0]     cfg_wdata_i = '0;
  logic [NQ-1:0]  gnt_o;

  int n_chk = 0, n_fail = 0;
  int mbal[NQ], mcost[NQ], mlen[NQ];
  int mptr = 0, mcnt = 0;
  logic [NQ-1:0] last_gnt;

  always #2 clk = ~clk;

  always_comb
    for (int q = 0; q < NQ; q++) len_i[q*LW +: LW] = LW'(mlen[q]);

  prio_dwrr_arb #(.QUANTUM(QUANT)) uut (
    .clk_i(clk), .rst_ni, .req_i, .len_i, .ready_i,
    .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .gnt_o
  );

  typedef struct packed { logic [5:0] cnt; logic [7:0] req; logic rdy; logic [7:0] exp; } vec_t;
  localparam vec_t VECS [10] = '{
    '{6'd0,  8'h00, 1'b1, 8'h00},  // R2 no request
    '{6'd0,  8'hA5, 1'b1, 8'h80},  // R4 R6 all strict
    '{6'd0,  8'h0F, 1'b1, 8'h08},  // R4
    '{6'd0,  8'hFF, 1'b0, 8'h00},  // R2 not ready
    '{6'd4,  8'h1F, 1'b1, 8'h10},  // R5 strict over group
    '{6'd4,  8'h0E, 1'b1, 8'h02},  // R8 pointer at 0
    '{6'd15, 8'h81, 1'b1, 8'h80},  // R6 clamp, R8 pointer at 2
    '{6'd7,  8'h81, 1'b1, 8'h80},  // R4
    '{6'd8,  8'h81, 1'b1, 8'h01},  // R8 pointer wrapped
    '{6'd4,  8'h00, 1'b1, 8'h00}   // R2
  };

  task automatic check(input logic [NQ-1:0] act, input logic [NQ-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [NQ-1:0] req, input logic rdy, output logic [NQ-1:0] exp);
    logic [NQ-1:0] act;
    int spick, pick, k;
    bit any_ok;
    exp = '0; spick = -1; act = '0;
    for (int q = 0; q < NQ; q++) begin
      if (req[q] && q >= mcnt) spick = q;
      act[q] = req[q] && (q < mcnt);
    end
    if (rdy && spick >= 0) exp[spick] = 1'b1;
    else if (rdy && act != '0) begin
      any_ok = 0;
      for (int q = 0; q < NQ; q++) if (act[q] && mbal[q] >= 0) any_ok = 1;
      if (!any_ok) for (int q = 0; q < NQ; q++) if (act[q]) mbal[q] += QUANT;
      pick = -1;
      for (int i = 0; i < NQ; i++) begin
        k = (mptr + i) % NQ;
        if (pick < 0 && act[k] && mbal[k] >= 0) pick = k;
      end
      if (pick >= 0) begin
        exp[pick] = 1'b1;
        mbal[pick] -= mlen[pick] * (mcost[pick] + 1);
        mptr = (mbal[pick] < 0) ? (pick + 1) % NQ : pick;
      end
    end
    for (int q = 0; q < NQ; q++) if (!act[q]) mbal[q] = 0;
  endtask

  task automatic step(input logic [NQ-1:0] req, input logic rdy, input string tag);
    logic [NQ-1:0] exp;
    model(req, rdy, exp);
    @(negedge clk);
    req_i = req; ready_i = rdy;
    @(posedge clk); #1;
    last_gnt = gnt_o;
    check(gnt_o, exp, tag);
  endtask

  task automatic cfg_write(input logic [3:0] addr, input logic [5:0] data);
    logic [NQ-1:0] dummy;
    model('0, 1'b0, dummy);
    @(negedge clk);
    req_i = '0; ready_i = 1'b0;
    cfg_we_i = 1'b1; cfg_addr_i = addr; cfg_wdata_i = data;
    @(posedge clk); #1;
    cfg_we_i = 1'b0;
    if (addr == 4'd8) mcnt = (data > 8) ? 8 : int'(data);
    else if (addr < 4'd8) mcost[addr[2:0]] = int'(data);
  endtask

  initial begin
    #600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int g[NQ];
    for (int q = 0; q < NQ; q++) begin mbal[q] = 0; mcost[q] = 0; mlen[q] = 64; end
    repeat (3) @(posedge clk);
    #1 check(gnt_o, '0, "R1 reset grant");
    @(negedge clk); rst_ni = 1'b1;

    // R1: count 0 after reset, all strict
    step(8'h03, 1'b1, "R1 count reset to 0");

    for (int i = 0; i < 10; i++) begin
      cfg_write(4'd8, VECS[i].cnt);
      step(VECS[i].req, VECS[i].rdy, "R2/R4/R5/R6/R8 table");
      if (last_gnt !== VECS[i].exp) $display("FAIL table %0d: gnt_o=%h expected %h", i, last_gnt, VECS[i].exp);
      n_chk++;
      if (last_gnt !== VECS[i].exp) n_fail++;
    end

    // R7: write to address above 8 is ignored
    cfg_write(4'd12, 6'd1);
    step(8'h11, 1'b1, "R7 ignored address keeps count 4");

    // R1: costs reset to 0, weighted sequence with cost 0
    cfg_write(4'd8, 6'd2);
    mlen[0] = 100; mlen[1] = 100;
    for (int i = 0; i < 6; i++) step(8'h03, 1'b1, "R1 default cost");

    // R8 R9: costs 0/1/3, mixed ready
    cfg_write(4'd1, 6'd1);
    cfg_write(4'd2, 6'd3);
    cfg_write(4'd8, 6'd3);
    mlen[2] = 100;
    for (int q = 0; q < NQ; q++) g[q] = 0;
    for (int i = 0; i < 96; i++) begin
      step(8'h07, (i % 11) != 5, "R8 R9 weighted rotation");
      for (int q = 0; q < NQ; q++) if (last_gnt[q]) g[q]++;
    end
    n_chk++;
    if (!(g[0] > g[1] && g[1] > g[2])) begin
      n_fail++;
      $display("FAIL R8 share: grants %0d/%0d/%0d expected decreasing", g[0], g[1], g[2]);
    end

    // R10: idle queue loses its debt
    cfg_write(4'd8, 6'd2);
    cfg_write(4'd1, 6'd0);
    mlen[0] = 200; mlen[1] = 20;
    for (int i = 0; i < 5; i++) step(8'h03, 1'b1, "R10 before idle");
    step(8'h02, 1'b1, "R10 queue 0 idle");
    step(8'h02, 1'b1, "R10 queue 0 idle");
    for (int i = 0; i < 6; i++) step(8'h03, 1'b1, "R10 after idle");

    // R9: charge far above quantum stalls on repeated top-ups
    cfg_write(4'd8, 6'd1);
    cfg_write(4'd0, 6'd63);
    mlen[0] = 16383;
    for (int i = 0; i < 8; i++) step(8'h01, 1'b1, "R9 large charge");
    step(8'h81, 1'b1, "R5 strict during debt");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule